// File: doc/BRIEF.md
# Message and Fault Interrupt Aggregator

This block gathers interrupt requests from two kinds of source into one pending register and drives one active-high interrupt line. The first source is a message-bus receive path. It raises a one-cycle strobe whenever a receive filter accepts a frame, and the strobe carries the 8-bit number of that filter. The second source is a set of four fault strobes: an EEPROM copy mismatch, an auto-initialisation verify mismatch, an auto-initialisation checksum error, and a RAM self-test failure.

A frame raises an interrupt only if the entry for its filter in a 256-entry, one-bit lookup table is set. When that happens, the filter number is latched. Host software can then use it as a relative pointer into receive memory. The frame interrupt can be masked. The fault interrupts cannot be masked.

The host reaches the pending register, the mask register, the captured filter number and the lookup table through a simple register port. A write completes in one cycle. A read is combinational from the address.

Top module: `msg_fault_irq_top`

## Requirements
- R1: The frame pending bit (pending bit 0) is set by a frame strobe only when the lookup entry indexed by the strobe's filter number is 1. A strobe whose entry is 0 leaves the pending bit and the captured number unchanged.
- R2: On a frame strobe that sets the pending bit, the filter number is stored in the capture register (address 0x002, bits 7:0). For example, filter 0xA1 stores 0xA1.
- R3: A pending frame bit drives the interrupt output only while mask bit 0 (address 0x001) is 1.
- R4: The four fault strobes set pending bits 1 to 4 (copy mismatch, verify mismatch, checksum error, RAM self-test failure). The pending register is at address 0x000, and bits 7:5 read 0.
- R5: Mask bits 1 to 4 always read 1 and ignore writes. Any pending fault bit asserts the interrupt output, whatever the mask.
- R6: The interrupt output is registered. It equals the OR over all bits of (pending AND mask), taken one clock earlier.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins, so the bit stays set.
- R8: Lookup entry n is written and read at address 0x100+n, using data bit 0. All entries are 0 after reset.
- R9: Reset clears the pending bits, the capture register, mask bit 0, the interrupt output and the lookup table.
- R10: Low addresses 0x003 to 0x0FF read as 0, and writes to them have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One-cycle strobe: a filter accepted a frame |
| frameFilter | input | 8 | Number of the accepting filter |
| faultCopy | input | 1 | EEPROM copy mismatch event |
| faultVerify | input | 1 | Auto-initialisation verify mismatch event |
| faultChecksum | input | 1 | Auto-initialisation checksum error event |
| faultRam | input | 1 | RAM self-test failure event |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | 9 | Host register address |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Host read data, combinational from regAddr |
| irqOut | output | 1 | Active-high interrupt output |

## Verification
The bench targets the cycle in which a host write-1-to-clear to the pending register meets a new set event for the same bit. This is provoked in two ways. A fault strobe is pulsed in the same cycle as a clear of its bit. A frame strobe that hits an enabled lookup entry is issued together with a clear of the frame bit. Both collisions also occur by chance in the random phase. The outcome is judged by reading back the pending register and by the interrupt output one cycle later: the bit must remain set and the output must stay high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_FAULTS = 4;
  localparam int PEND_W     = 1 + NUM_FAULTS;

  // Host-side strobes produced by the control decode
  typedef struct packed {
    logic wrPend;
    logic wrMask;
    logic wrLut;
  } hostStrobe_t;

  typedef enum logic [2:0] {
    SEL_PEND = 3'd0,
    SEL_MASK = 3'd1,
    SEL_CAP  = 3'd2,
    SEL_LUT  = 3'd3,
    SEL_NONE = 3'd4
  } readSel_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int FILTER_W = 8,
  parameter int DATA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [FILTER_W:0]     regAddr,
  input  logic [PEND_W-1:0]     pendVec,
  input  logic [PEND_W-1:0]     maskVec,
  input  logic [FILTER_W-1:0]   capAddr,
  input  logic                  lutRdBit,
  output hostStrobe_t           strb,
  output logic [FILTER_W-1:0]   lutIdx,
  output logic [DATA_W-1:0]     regRdData
);

  localparam int ADDR_W = FILTER_W + 1;

  readSel_t sel;
  logic     lutSpace;

  assign lutSpace = regAddr[ADDR_W-1];
  assign lutIdx   = regAddr[FILTER_W-1:0];

  always_comb begin
    if (lutSpace) begin
      sel = SEL_LUT;
    end else begin
      case (regAddr[FILTER_W-1:0])
        FILTER_W'(0): sel = SEL_PEND;
        FILTER_W'(1): sel = SEL_MASK;
        FILTER_W'(2): sel = SEL_CAP;
        default:      sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb.wrPend = regWrEn && (sel == SEL_PEND);
    strb.wrMask = regWrEn && (sel == SEL_MASK);
    strb.wrLut  = regWrEn && (sel == SEL_LUT);
  end

  always_comb begin
    case (sel)
      SEL_PEND: regRdData = DATA_W'(pendVec);
      SEL_MASK: regRdData = DATA_W'(maskVec);
      SEL_CAP:  regRdData = DATA_W'(capAddr);
      SEL_LUT:  regRdData = DATA_W'(lutRdBit);
      default:  regRdData = '0;
    endcase
  end

  // R10: a write to an unmapped low address raises no strobe
  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !lutSpace && (regAddr[FILTER_W-1:0] > FILTER_W'(2))) |-> (strb == '0));

  // R5: the fault mask bits always read back as ones
  assert_fault_mask_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_MASK) |-> (regRdData[PEND_W-1:1] == '1));

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int FILTER_W = 8,
  parameter int DATA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameValid,
  input  logic [FILTER_W-1:0]   frameFilter,
  input  logic [NUM_FAULTS-1:0] faultEv,
  input  hostStrobe_t           strb,
  input  logic [FILTER_W-1:0]   lutIdx,
  input  logic [DATA_W-1:0]     wrData,
  output logic [PEND_W-1:0]     pendVec,
  output logic [PEND_W-1:0]     maskVec,
  output logic [FILTER_W-1:0]   capAddr,
  output logic                  lutRdBit,
  output logic                  irqOut
);

  localparam int NUM_FILTERS = 1 << FILTER_W;

  logic [NUM_FILTERS-1:0] lutBits;
  logic                   maskFrame;
  logic                   lutHit;
  logic [PEND_W-1:0]      setVec;
  logic [PEND_W-1:0]      clrVec;

  assign lutHit   = frameValid && lutBits[frameFilter];
  assign setVec   = {faultEv, lutHit};
  assign clrVec   = strb.wrPend ? wrData[PEND_W-1:0] : '0;
  assign maskVec  = {{NUM_FAULTS{1'b1}}, maskFrame};
  assign lutRdBit = lutBits[lutIdx];

  // Pending bits: a set event wins over a same-cycle clear
  generate
    for (genvar b = 0; b < PEND_W; b++) begin : g_pend
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pendVec[b] <= 1'b0;
        else       pendVec[b] <= (pendVec[b] & ~clrVec[b]) | setVec[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr   <= '0;
      maskFrame <= 1'b0;
      irqOut    <= 1'b0;
      lutBits   <= '0;
    end else begin
      if (lutHit)      capAddr   <= frameFilter;
      if (strb.wrMask) maskFrame <= wrData[0];
      if (strb.wrLut)  lutBits[lutIdx] <= wrData[0];
      irqOut <= |(pendVec & maskVec);
    end
  end

  assert_frame_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendVec[0]) |-> ($past(frameValid) && $past(lutBits[frameFilter])));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && lutBits[frameFilter]) |=> (capAddr == $past(frameFilter)));

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!maskFrame && (pendVec[PEND_W-1:1] == '0)) |=> !irqOut);

  assert_fault_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|faultEv) |=> ((pendVec[PEND_W-1:1] & $past(faultEv)) == $past(faultEv)));

  assert_fault_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|pendVec[PEND_W-1:1]) |=> irqOut);

  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (maskFrame && pendVec[0]) |=> irqOut);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPend && wrData[0] && !lutHit) |=> !pendVec[0]);

  assert_lut_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLut |=> (lutBits[$past(lutIdx)] == $past(wrData[0])));

endmodule

// File: rtl/msg_fault_irq_top.sv
module msg_fault_irq_top
  import irq_agg_pkg::*;
#(
  parameter int FILTER_W = 8,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameValid,
  input  logic [FILTER_W-1:0] frameFilter,
  input  logic                faultCopy,
  input  logic                faultVerify,
  input  logic                faultChecksum,
  input  logic                faultRam,
  input  logic                regWrEn,
  input  logic [FILTER_W:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqOut
);

  hostStrobe_t           strb;
  logic [FILTER_W-1:0]   lutIdx;
  logic [PEND_W-1:0]     pendVec;
  logic [PEND_W-1:0]     maskVec;
  logic [FILTER_W-1:0]   capAddr;
  logic                  lutRdBit;
  logic [NUM_FAULTS-1:0] faultEv;

  assign faultEv = {faultRam, faultChecksum, faultVerify, faultCopy};

  irq_agg_ctrl #(.FILTER_W(FILTER_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .pendVec(pendVec), .maskVec(maskVec), .capAddr(capAddr),
    .lutRdBit(lutRdBit), .strb(strb), .lutIdx(lutIdx),
    .regRdData(regRdData)
  );

  irq_agg_dp #(.FILTER_W(FILTER_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .frameFilter(frameFilter), .faultEv(faultEv), .strb(strb),
    .lutIdx(lutIdx), .wrData(regWrData), .pendVec(pendVec),
    .maskVec(maskVec), .capAddr(capAddr), .lutRdBit(lutRdBit),
    .irqOut(irqOut)
  );

endmodule

// File: tb/sim_msg_fault_irq_top.sv
module sim_msg_fault_irq_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic [7:0] frameFilter = '0;
  logic       faultCopy = 1'b0, faultVerify = 1'b0, faultChecksum = 1'b0, faultRam = 1'b0;
  logic       regWrEn = 1'b0;
  logic [8:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  // Expected state
  bit [4:0]   ePend;
  bit         eMask;
  bit [7:0]   eCap;
  bit         eIrq;
  bit [255:0] eLut;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_fault_irq_top u0 (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameFilter(frameFilter),
    .faultCopy(faultCopy), .faultVerify(faultVerify), .faultChecksum(faultChecksum),
    .faultRam(faultRam), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic bit [7:0] expRead(input bit [8:0] a);
    if (a[8])           return {7'b0, eLut[a[7:0]]};
    else if (a == 9'd0) return {3'b0, ePend};
    else if (a == 9'd1) return {3'b0, 4'hF, eMask};
    else if (a == 9'd2) return eCap;
    else                return 8'h00;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic modelReset();
    ePend = '0; eMask = 1'b0; eCap = '0; eIrq = 1'b0; eLut = '0;
  endtask

  // Drive one cycle of stimulus at a negedge, update the model at the edge
  task automatic cycle(input bit fv, input bit [7:0] filt, input bit [3:0] flt,
                       input bit we, input bit [8:0] a, input bit [7:0] d);
    bit [4:0] setV;
    bit [4:0] clrV;
    frameValid = fv; frameFilter = filt;
    {faultRam, faultChecksum, faultVerify, faultCopy} = flt;
    regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    eIrq = |(ePend & {4'hF, eMask});
    setV = {flt, fv && eLut[filt]};
    clrV = (we && a == 9'd0) ? d[4:0] : 5'd0;
    if (fv && eLut[filt]) eCap = filt;
    ePend = (ePend & ~clrV) | setV;
    if (we && a == 9'd1) eMask = d[0];
    if (we && a[8]) eLut[a[7:0]] = d[0];
    @(negedge clk);
    frameValid = 1'b0;
    {faultRam, faultChecksum, faultVerify, faultCopy} = 4'b0;
    regWrEn = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 8'h0, 4'h0, 1'b0, 9'h0, 8'h0);
  endtask

  task automatic readChk(input string tag, input bit [8:0] a);
    regAddr = a;
    #1;
    chk(tag, regRdData, expRead(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    readChk("R9 pending after reset", 9'h000);
    readChk("R9 mask after reset", 9'h001);
    readChk("R9 capture after reset", 9'h002);
    readChk("R8 lut entry 0xA1 after reset", 9'h1A1);
    chk("R9 irq after reset", irqOut, 0);

    // R1: frame on a disabled entry is ignored
    cycle(1'b1, 8'hA1, 4'h0, 1'b0, 9'h0, 8'h0);
    readChk("R1 pending ignores disabled filter", 9'h000);
    readChk("R1 capture unchanged", 9'h002);

    // R8: write and read back lookup entry
    cycle(1'b0, 8'h0, 4'h0, 1'b1, 9'h1A1, 8'h01);
    readChk("R8 lut entry 0xA1 written", 9'h1A1);
    readChk("R8 neighbour entry untouched", 9'h1A0);

    // R2 / R3: enabled frame sets pending, captures number, masked irq
    cycle(1'b1, 8'hA1, 4'h0, 1'b0, 9'h0, 8'h0);
    readChk("R1 pending frame bit set", 9'h000);
    readChk("R2 capture 0xA1", 9'h002);
    chk("R2 capture literal", regRdData, 8'hA1);
    idle();
    chk("R3 irq held off by mask", irqOut, 0);

    // R6: mask write shows on irq one clock later
    cycle(1'b0, 8'h0, 4'h0, 1'b1, 9'h001, 8'h01);
    chk("R6 irq not yet after mask write", irqOut, 0);
    idle();
    chk("R3 irq after mask set", irqOut, 1);

    // R5: fault mask bits ignore writes
    cycle(1'b0, 8'h0, 4'h0, 1'b1, 9'h001, 8'h00);
    readChk("R5 mask after writing zero", 9'h001);
    chk("R5 mask literal", regRdData, 8'h1E);
    idle();
    chk("R3 irq drops with mask clear", irqOut, 0);

    // R7: W1C of frame bit with a same-cycle enabled frame: set wins
    cycle(1'b1, 8'hA1, 4'h0, 1'b1, 9'h000, 8'h01);
    readChk("R7 frame set wins over clear", 9'h000);
    cycle(1'b0, 8'h0, 4'h0, 1'b1, 9'h000, 8'h01);
    readChk("R7 frame bit cleared", 9'h000);

    // R4 / R5: each fault sets its bit and raises irq regardless of mask
    for (int f = 0; f < 4; f++) begin
      cycle(1'b0, 8'h0, 4'(1 << f), 1'b0, 9'h0, 8'h0);
      readChk("R4 fault bit set", 9'h000);
      idle();
      chk("R5 fault irq unmaskable", irqOut, 1);
      cycle(1'b0, 8'h0, 4'h0, 1'b1, 9'h000, 8'(2 << f));
    end
    idle();
    chk("R7 irq low after clearing faults", irqOut, 0);

    // R7: fault set in the same cycle as its clear
    cycle(1'b0, 8'h0, 4'b0010, 1'b1, 9'h000, 8'h04);
    readChk("R7 verify fault set wins", 9'h000);
    chk("R7 verify literal", regRdData, 8'h04);
    idle();
    chk("R7 irq stays high", irqOut, 1);

    // R10: unmapped address reads zero and writes have no effect
    cycle(1'b0, 8'h0, 4'h0, 1'b1, 9'h003, 8'hFF);
    readChk("R10 unmapped reads zero", 9'h003);
    readChk("R10 pending untouched", 9'h000);
    readChk("R10 mask untouched", 9'h001);
    readChk("R10 unmapped 0xFF reads zero", 9'h0FF);

    // R9: reset mid-run
    rstN = 1'b0;
    #1;
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readChk("R9 pending cleared", 9'h000);
    readChk("R9 capture cleared", 9'h002);
    readChk("R9 lut cleared", 9'h1A1);
    chk("R9 irq cleared", irqOut, 0);

    // Random phase
    for (int i = 0; i < 600; i++) begin
      bit [8:0] a;
      int pick = $urandom_range(0, 7);
      case (pick)
        0, 1: a = 9'h000;
        2:    a = 9'h001;
        3:    a = 9'h002;
        4:    a = 9'h003;
        default: a = {1'b1, 4'h0, 4'($urandom_range(0, 15))};
      endcase
      cycle($urandom_range(0, 2) == 0, {4'h0, 4'($urandom_range(0, 15))},
            ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0,
            $urandom_range(0, 1) == 1, a, 8'($urandom));
      chk("R6 irq random", irqOut, eIrq);
      if (i % 3 == 0) readChk("R7 pending random", 9'h000);
      if (i % 5 == 0) readChk("R2 capture random", 9'h002);
      if (i % 7 == 0) readChk("R8 lut random", {1'b1, 4'h0, 4'($urandom_range(0, 15))});
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule